// File: doc/BRIEF.md
# Level-Masked Priority Interrupt Controller

This block collects interrupt requests from `NSRC = 2^LVL_W` sources and presents a single interrupt line to the CPU. Each source has a sticky request flag and an enable bit. A priority encoder picks the highest-indexed source that is both pending and enabled. The interrupt line is raised only if that source outranks the handler that is currently running, which is tracked in a loadable level register.

When the CPU acknowledges, the controller does four things in the same cycle. It places the winner's 8-bit vector and 16-bit information word on the return bus. It sends a one-hot acknowledge to that source alone. It clears the source's request flag. It records the source as the running level. Software lowers the level again when a handler finishes, so nested handling works: only strictly higher sources can interrupt a running handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all request flags and enable bits are clear, the level register is 0, and `irq_o`, `src_ack_o` and `data_o` are all zero.
- R2: A source's request flag is set at any clock edge where its `ready_i` bit is 1. It stays set after `ready_i` falls, until that source is acknowledged.
- R3: The enable register is loaded from `en_wdata_i` when `en_we_i` is 1. A source whose enable bit is 0 never raises `irq_o` and never receives an acknowledge. Its request flag is kept, and it takes part again as soon as it is enabled.
- R4: Among the sources that are both pending and enabled, the one with the highest index wins.
- R5: The level register holds 0 when no handler runs, and j+1 while the handler for source j runs. `irq_o` is 1 exactly when a winner w exists and w+1 is greater than the level.
- R6: When `lvl_we_i` is 1 and no acknowledge takes place, the level register loads `lvl_wdata_i`.
- R7: An acknowledge cycle is a cycle with both `iack_i` and `irq_o` at 1. In that cycle, `src_ack_o` has only bit w set. `data_o[23:16]` carries the winner's vector, `data_o[15:0]` carries its information word, and `data_o[31:24]` is 0.
- R8: Outside acknowledge cycles, including cycles where `iack_i` is 1 while `irq_o` is 0, `data_o` and `src_ack_o` are zero and no state changes.
- R9: At the clock edge that ends an acknowledge cycle, the level becomes w+1, even if `lvl_we_i` is 1 in the same cycle. The winner's request flag is cleared, unless its `ready_i` bit is 1 in that cycle, in which case the flag stays set.
- R10: While a handler runs, pending sources at or below its level do not raise `irq_o`, while a higher pending source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | NSRC | Per-source ready condition; sets the request flag |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NSRC | New enable mask, one bit per source |
| lvl_we_i | input | 1 | Level register write strobe |
| lvl_wdata_i | input | LVL_W+1 | New level (0 = idle, j+1 = handler j) |
| vec_i | input | NSRC*8 | Vector of each source; source i at bits [8i+7:8i] |
| info_i | input | NSRC*16 | Information word of each source; source i at bits [16i+15:16i] |
| iack_i | input | 1 | CPU interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the CPU |
| src_ack_o | output | NSRC | One-hot acknowledge to the winning source |
| data_o | output | 32 | Return bus: vector at [23:16], information word at [15:0] |

## Verification
A table of request and enable patterns, each combined with a loaded level, is tried against the arbitration and the level gate. The table covers:
- a lone request;
- requests at both ends of the range, which separate the highest-index rule from the lowest-index rule;
- a masked top source, which shows that the enable bit steers the choice to a lower source;
- winners whose level equals the running level and winners one above it, which show the comparison is strict.

Directed sequences then cover the following:
- A short ready pulse, which checks that the request flag is sticky.
- A disabled source that is pending and is enabled later.
- A stray acknowledge while no interrupt is raised.
- Same-cycle collisions of acknowledge with a new ready event, and of acknowledge with a level write.
- A nested sequence in which a lower source is held off, a higher one preempts, and restoring the level releases the held-off source.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned INFO_W  = 16;
  localparam int unsigned VEC_LSB = 16;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] ready_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] req_q, en_q;

  // a fresh ready event outranks the acknowledge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      req_q <= (req_q & ~clr_i) | ready_i;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign pend_o = req_q & en_q;

  AST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_q & $past(req_q & ~clr_i)) == $past(req_q & ~clr_i))); // R2
  AST_READY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_q & $past(ready_i)) == $past(ready_i))); // R9
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned LVL_W = 3,
  localparam int unsigned NSRC = 1 << LVL_W
) (
  input  logic [NSRC-1:0]  act_i,
  output logic             any_o,
  output logic [LVL_W-1:0] idx_o
);
  // later (higher) index overrides earlier ones
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (act_i[i]) idx_o = LVL_W'(i);
    end
  end

  assign any_o = |act_i;
endmodule

// File: rtl/irq_lvl_gate.sv
module irq_lvl_gate #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [LVL_W-1:0] idx_i,
  input  logic             lvl_we_i,
  input  logic [LVL_W:0]   lvl_wdata_i,
  input  logic             take_i,
  output logic             irq_o
);
  logic [LVL_W:0] lvl_q, cand;

  assign cand = {1'b0, idx_i} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lvl_q <= '0;
    else if (take_i)   lvl_q <= cand;
    else if (lvl_we_i) lvl_q <= lvl_wdata_i;
  end

  assign irq_o = any_i && (cand > lvl_q);

  AST_LVL_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (lvl_q == $past(cand))); // R9
  AST_LVL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_we_i && !take_i) |=> (lvl_q == $past(lvl_wdata_i))); // R6
  AST_NO_REENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !(irq_o && (idx_i == $past(idx_i)))); // R10
endmodule

// File: rtl/irq_ack_dec.sv
module irq_ack_dec
  import prio_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 3,
  localparam int unsigned NSRC = 1 << LVL_W
) (
  input  logic                   take_i,
  input  logic [LVL_W-1:0]       idx_i,
  input  logic [NSRC*VEC_W-1:0]  vec_i,
  input  logic [NSRC*INFO_W-1:0] info_i,
  output logic [NSRC-1:0]        src_ack_o,
  output logic [BUS_W-1:0]       data_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_dec
    assign src_ack_o[g] = take_i && (idx_i == LVL_W'(g));
  end

  logic [VEC_W-1:0]  vec_sel;
  logic [INFO_W-1:0] info_sel;
  assign vec_sel  = vec_i[idx_i*VEC_W +: VEC_W];
  assign info_sel = info_i[idx_i*INFO_W +: INFO_W];

  always_comb begin
    data_o = '0;
    if (take_i) begin
      data_o[VEC_LSB +: VEC_W] = vec_sel;
      data_o[INFO_W-1:0]       = info_sel;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 3,
  localparam int unsigned NSRC = 1 << LVL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSRC-1:0]        ready_i,
  input  logic                   en_we_i,
  input  logic [NSRC-1:0]        en_wdata_i,
  input  logic                   lvl_we_i,
  input  logic [LVL_W:0]         lvl_wdata_i,
  input  logic [NSRC*VEC_W-1:0]  vec_i,
  input  logic [NSRC*INFO_W-1:0] info_i,
  input  logic                   iack_i,
  output logic                   irq_o,
  output logic [NSRC-1:0]        src_ack_o,
  output logic [BUS_W-1:0]       data_o
);
  logic [NSRC-1:0]  pend;
  logic             any;
  logic [LVL_W-1:0] win;
  logic             take;

  assign take = iack_i && irq_o;

  irq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (ready_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .clr_i      (src_ack_o),
    .pend_o     (pend)
  );

  irq_prio_enc #(.LVL_W(LVL_W)) u_enc (
    .act_i (pend),
    .any_o (any),
    .idx_o (win)
  );

  irq_lvl_gate #(.LVL_W(LVL_W)) u_lvl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .any_i       (any),
    .idx_i       (win),
    .lvl_we_i    (lvl_we_i),
    .lvl_wdata_i (lvl_wdata_i),
    .take_i      (take),
    .irq_o       (irq_o)
  );

  irq_ack_dec #(.LVL_W(LVL_W)) u_dec (
    .take_i    (take),
    .idx_i     (win),
    .vec_i     (vec_i),
    .info_i    (info_i),
    .src_ack_o (src_ack_o),
    .data_o    (data_o)
  );

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_ack_o)); // R7
  AST_ACK_ONLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ack_o & ~pend) == '0); // R3
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend != '0)); // R3
  AST_WIN_IS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |-> ((pend >> win) == NSRC'(1))); // R4
  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |-> (data_o == '0 && src_ack_o == '0)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_ack_o != '0) && ((src_ack_o & ready_i) == '0)) |=> ((pend & $past(src_ack_o)) == '0)); // R9
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned NSRC  = 1 << LVL_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NSRC-1:0]   ready_i = '0;
  logic              en_we_i = 1'b0;
  logic [NSRC-1:0]   en_wdata_i = '0;
  logic              lvl_we_i = 1'b0;
  logic [LVL_W:0]    lvl_wdata_i = '0;
  logic [NSRC*8-1:0]  vec_i;
  logic [NSRC*16-1:0] info_i;
  logic              iack_i = 1'b0;
  logic              irq_o;
  logic [NSRC-1:0]   src_ack_o;
  logic [31:0]       data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] vecv(input int i);
    return 8'(8'hA0 + i);
  endfunction
  function automatic logic [15:0] infov(input int i);
    return 16'(16'hC000 | (i * 16'h0111));
  endfunction

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      vec_i[i*8 +: 8]   = vecv(i);
      info_i[i*16 +: 16] = infov(i);
    end
  end

  prio_irq_ctrl #(.LVL_W(LVL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ready_i(ready_i),
    .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
    .lvl_we_i(lvl_we_i), .lvl_wdata_i(lvl_wdata_i),
    .vec_i(vec_i), .info_i(info_i), .iack_i(iack_i),
    .irq_o(irq_o), .src_ack_o(src_ack_o), .data_o(data_o)
  );

  // {ready[23:16], enable[15:8], level[7:4], exp_irq[3], exp_idx[2:0]}
  localparam logic [23:0] VTAB [12] = '{
    24'h01FF08, 24'h81FF0F, 24'h817F08, 24'h00FF00,
    24'h24FF3D, 24'h24FF60, 24'h24DF2A, 24'h24DF30,
    24'hFF0000, 24'h10FF80, 24'h5A0F1B, 24'hFFFF7F
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; ready_i = '0; en_we_i = 0; lvl_we_i = 0; iack_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] rdy, input logic [7:0] en, input logic [3:0] lvl);
    ready_i = rdy; en_we_i = 1; en_wdata_i = en; lvl_we_i = 1; lvl_wdata_i = lvl;
    @(negedge clk);
    ready_i = '0; en_we_i = 0; lvl_we_i = 0;
  endtask

  task automatic lvl_load(input logic [3:0] v);
    lvl_we_i = 1; lvl_wdata_i = v;
    @(negedge clk);
    lvl_we_i = 0;
  endtask

  task automatic pulse_ready(input logic [7:0] r);
    ready_i = r;
    @(negedge clk);
    ready_i = '0;
  endtask

  task automatic ack_check(input int idx, input string tag);
    chk({tag, " irq before ack R5"}, 32'(irq_o), 32'd1);
    iack_i = 1;
    #1;
    chk({tag, " ack one-hot R7"}, 32'(src_ack_o), 32'(1 << idx));
    chk({tag, " data R7"}, data_o, {8'h00, vecv(idx), infov(idx)});
    @(negedge clk);
    iack_i = 0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ack", 32'(src_ack_o), 0);
    chk("R1 data", data_o, 0);

    // R4 R5 R3 table walk
    foreach (VTAB[v]) begin
      do_reset();
      setup(VTAB[v][23:16], VTAB[v][15:8], VTAB[v][7:4]);
      chk($sformatf("R4/R5 vec%0d irq", v), 32'(irq_o), 32'(VTAB[v][3]));
      if (VTAB[v][3]) ack_check(int'(VTAB[v][2:0]), $sformatf("R4 vec%0d", v));
      else chk($sformatf("R3 vec%0d no ack", v), 32'(src_ack_o), 0);
    end

    // R2 sticky request
    do_reset();
    setup(8'h04, 8'hFF, 4'd0);
    repeat (3) @(negedge clk);
    ack_check(2, "R2 sticky");

    // R3 pending while disabled, then enabled
    do_reset();
    setup(8'h40, 8'h00, 4'd0);
    chk("R3 disabled irq", 32'(irq_o), 0);
    en_we_i = 1; en_wdata_i = 8'hFF;
    @(negedge clk);
    en_we_i = 0;
    ack_check(6, "R3 enabled later");

    // R8 stray acknowledge
    do_reset();
    setup(8'h00, 8'hFF, 4'd0);
    iack_i = 1;
    #1;
    chk("R8 stray data", data_o, 0);
    chk("R8 stray ack", 32'(src_ack_o), 0);
    @(negedge clk);
    iack_i = 0;
    pulse_ready(8'h01);
    ack_check(0, "R8 level untouched");

    // R9 ack clears request
    do_reset();
    setup(8'h01, 8'hFF, 4'd0);
    ack_check(0, "R9 clear");
    lvl_load(4'd0);
    chk("R9 cleared irq", 32'(irq_o), 0);

    // R9 same-cycle ready keeps flag
    do_reset();
    setup(8'h08, 8'hFF, 4'd0);
    ready_i = 8'h08;
    ack_check(3, "R9 set-wins");
    ready_i = '0;
    lvl_load(4'd0);
    ack_check(3, "R9 flag kept");

    // R9 ack overrides level write
    do_reset();
    setup(8'h03, 8'hFF, 4'd0);
    lvl_we_i = 1; lvl_wdata_i = 4'd0;
    ack_check(1, "R9 ack vs lvl");
    lvl_we_i = 0;
    chk("R9 level from ack irq", 32'(irq_o), 0);
    lvl_load(4'd0);
    ack_check(0, "R6 release low");

    // R10 nesting, R6 restore
    do_reset();
    setup(8'h04, 8'hFF, 4'd0);
    ack_check(2, "R10 first");
    pulse_ready(8'h02);
    chk("R10 lower held", 32'(irq_o), 0);
    pulse_ready(8'h10);
    ack_check(4, "R10 preempt");
    lvl_load(4'd3);
    chk("R6 restored level holds low", 32'(irq_o), 0);
    lvl_load(4'd0);
    ack_check(1, "R6 idle releases");
    chk("R9 all served", 32'(irq_o), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule